// File: doc/BRIEF.md
# TLB Invalidation and Clear Engine

This block holds the existence state of a two-part translation lookaside buffer and carries out maintenance commands that drop entries. The buffer has a set-associative part of `WAYS` ways by `LINES` lines, all sharing one page size given on an input, and a small fully associative part in which every entry keeps its own page size. An entry holds a virtual page-pair number (address bits from 13 upward), a page size, a 10-bit address-space identifier and a global flag taken from the even-half entry word.

Entries are loaded through a write port while the engine is idle. A command is accepted in one idle cycle. The engine then walks the entries in its scope, one per cycle, and clears the exist bit of each entry that meets the command's condition. When the walk ends, a one-cycle pulse tells the translation caches downstream to flush. A combinational read port reports any entry's exist bit.

Top module: `tlbinv_engine`

## Requirements
- R1: After reset, every exist bit reads 0, `busy` is 0 and `flush_pulse` is 0.
- R2: When `busy` is 0, `wr_en` with `wr_idx` below the total entry count stores the entry and sets its exist bit. A write or a command presented while `busy` is 1 has no effect.
- R3: An accepted command raises `busy` in the next cycle. The engine checks one entry per cycle. Scan length: the total count for op codes 0 to 4; `WAYS` for a line operation; the associative count for a whole-associative-part operation; 0 for an out-of-range index or op code 7.
- R4: `flush_pulse` is high for exactly one cycle, in the cycle after the last entry checked (in the cycle after acceptance when nothing is scanned). It is the last cycle with `busy` high, and every command produces it.
- R5: Op 0 clears every entry. Op 1 clears the entries whose global flag equals `cmd_g`.
- R6: Op 2 clears the non-global entries whose identifier equals `cmd_asid`.
- R7: An entry's page matches when `cmd_va >> (ps+1)` equals `vppn >> (ps+1-13)`. Here `ps` is `stlb_ps` for indices below `WAYS*LINES` and the entry's own stored size above that.
- R8: Op 3 clears non-global, identifier-matching entries whose page matches. Op 4 clears page-matching entries that are global or whose identifier matches.
- R9: Ops 5 and 6 pick their scope from `cmd_index`. Below `WAYS*LINES` the scope is entries `way*LINES + cmd_index%LINES` for every way. From there up to the total count the scope is the whole associative part. At or above the total count nothing is cleared.
- R10: Op 5 clears only non-global entries in scope whose identifier equals `cmd_asid`. Op 6 clears every entry in scope.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stlb_ps | input | PS_W | Shared page size of the set-associative part |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_vppn | input | VA_W-13 | Virtual page-pair number to store |
| wr_ps | input | PS_W | Page size to store (used by the associative part) |
| wr_asid | input | ASID_W | Address-space identifier to store |
| wr_g | input | 1 | Global flag to store |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Op code: 0 all, 1 by global value, 2 by identifier, 3 page+identifier, 4 page and global-or-identifier, 5 clear, 6 flush, 7 none |
| cmd_g | input | 1 | Global value for op 1 |
| cmd_asid | input | ASID_W | Identifier for ops 2, 3, 4, 5 |
| cmd_va | input | VA_W | Virtual address for ops 3, 4 |
| cmd_index | input | IDX_W | Scope index for ops 5, 6 |
| rd_idx | input | IDX_W | Read index |
| rd_exist | output | 1 | Exist bit of entry `rd_idx` (0 if out of range) |
| busy | output | 1 | Command in progress |
| flush_pulse | output | 1 | Downstream translation-cache flush |

## Verification
The bench fills the buffer with entries drawn from a small pool of pages, identifiers and sizes, so page and identifier hits are common. Under mixed page sizes, a design that used the wrong size source for one half of the buffer would drop the wrong entries. Line operations use an index above `LINES`; a design that failed to wrap it would touch a single entry or the wrong line. Indices just past the set-associative part, and past the end of the buffer, check that the scope is picked correctly; a bad compare would wipe entries or skip the flush pulse. A command and a write arriving mid-scan check that a busy engine ignores them, and the global flag is varied to tell the clear operation apart from the global-or-identifier page operation.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;

    typedef enum logic [2:0] {
        OP_ALL       = 3'd0,
        OP_GVAL      = 3'd1,
        OP_ASID      = 3'd2,
        OP_PAGE      = 3'd3,
        OP_PAGE_OR_G = 3'd4,
        OP_CLEAR     = 3'd5,
        OP_FLUSH     = 3'd6,
        OP_NONE      = 3'd7
    } inv_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_st_e;

endpackage

// File: rtl/tlbinv_match.sv
module tlbinv_match
    import tlbinv_pkg::*;
#(
    parameter int VA_W     = 48,
    parameter int VPPN_LSB = 13,
    parameter int PS_W     = 6,
    parameter int ASID_W   = 10
) (
    input  inv_op_e                   op,
    input  logic                      cmd_g,
    input  logic [ASID_W-1:0]         cmd_asid,
    input  logic [VA_W-1:0]           cmd_va,
    input  logic                      ent_g,
    input  logic [ASID_W-1:0]         ent_asid,
    input  logic [VA_W-VPPN_LSB-1:0]  ent_vppn,
    input  logic [PS_W-1:0]           ps_eff,
    output logic                      kill
);
    localparam int SH_W = PS_W + 1;

    logic [VA_W-1:0] keep_mask;
    logic [VA_W-1:0] ent_addr;
    logic [SH_W-1:0] shamt;
    logic            page_hit;
    logic            asid_hit;

    always_comb begin
        shamt     = SH_W'(ps_eff) + SH_W'(1);
        keep_mask = ~((VA_W'(1) << shamt) - VA_W'(1));
        ent_addr  = {ent_vppn, VPPN_LSB'(0)};
        page_hit  = ((cmd_va & keep_mask) == (ent_addr & keep_mask));
        asid_hit  = (ent_asid == cmd_asid);
        unique case (op)
            OP_ALL:       kill = 1'b1;
            OP_GVAL:      kill = (ent_g == cmd_g);
            OP_ASID:      kill = !ent_g && asid_hit;
            OP_PAGE:      kill = !ent_g && asid_hit && page_hit;
            OP_PAGE_OR_G: kill = (ent_g || asid_hit) && page_hit;
            OP_CLEAR:     kill = !ent_g && asid_hit;
            OP_FLUSH:     kill = 1'b1;
            default:      kill = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlbinv_scan.sv
module tlbinv_scan
    import tlbinv_pkg::*;
#(
    parameter int WAYS   = 8,
    parameter int LINES  = 256,
    parameter int ASSOC  = 64,
    parameter int IDX_W  = 13,
    parameter int ASID_W = 10,
    parameter int VA_W   = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  inv_op_e           cmd_op,
    input  logic              cmd_g,
    input  logic [ASID_W-1:0] cmd_asid,
    input  logic [VA_W-1:0]   cmd_va,
    input  logic [IDX_W-1:0]  cmd_index,
    output logic              busy,
    output logic              flush_pulse,
    output logic              scan_active,
    output logic [IDX_W-1:0]  scan_ptr,
    output inv_op_e           op_q,
    output logic              g_q,
    output logic [ASID_W-1:0] asid_q,
    output logic [VA_W-1:0]   va_q
);
    localparam int SA_CNT = WAYS * LINES;
    localparam int TOTAL  = SA_CNT + ASSOC;

    typedef struct packed {
        scan_st_e          st;
        inv_op_e           op;
        logic [IDX_W-1:0]  ptr;
        logic [IDX_W-1:0]  last;
        logic [IDX_W-1:0]  step;
        logic              g;
        logic [ASID_W-1:0] asid;
        logic [VA_W-1:0]   va;
    } scan_s;

    scan_s s_d, s_q;
    logic [IDX_W-1:0] line_d;
    logic             ranged_op;

    always_comb begin
        s_d       = s_q;
        line_d    = cmd_index % IDX_W'(LINES);
        ranged_op = (cmd_op == OP_CLEAR) || (cmd_op == OP_FLUSH);
        unique case (s_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    s_d.op   = cmd_op;
                    s_d.g    = cmd_g;
                    s_d.asid = cmd_asid;
                    s_d.va   = cmd_va;
                    s_d.st   = ST_SCAN;
                    s_d.ptr  = '0;
                    s_d.step = IDX_W'(1);
                    s_d.last = IDX_W'(TOTAL - 1);
                    if (cmd_op == OP_NONE) begin
                        s_d.st = ST_DONE;
                    end else if (ranged_op) begin
                        if (cmd_index < IDX_W'(SA_CNT)) begin
                            s_d.ptr  = line_d;
                            s_d.step = IDX_W'(LINES);
                            s_d.last = IDX_W'((WAYS - 1) * LINES) + line_d;
                        end else if (cmd_index < IDX_W'(TOTAL)) begin
                            s_d.ptr  = IDX_W'(SA_CNT);
                        end else begin
                            s_d.st   = ST_DONE;
                        end
                    end
                end
            end
            ST_SCAN: begin
                if (s_q.ptr == s_q.last) begin
                    s_d.st = ST_DONE;
                end else begin
                    s_d.ptr = s_q.ptr + s_q.step;
                end
            end
            ST_DONE: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy        = (s_q.st != ST_IDLE);
    assign flush_pulse = (s_q.st == ST_DONE);
    assign scan_active = (s_q.st == ST_SCAN);
    assign scan_ptr    = s_q.ptr;
    assign op_q        = s_q.op;
    assign g_q         = s_q.g;
    assign asid_q      = s_q.asid;
    assign va_q        = s_q.va;
endmodule

// File: rtl/tlbinv_store.sv
module tlbinv_store #(
    parameter int TOTAL  = 2112,
    parameter int IDX_W  = 13,
    parameter int VPPN_W = 35,
    parameter int PS_W   = 6,
    parameter int ASID_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPPN_W-1:0] wr_vppn,
    input  logic [PS_W-1:0]   wr_ps,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_g,
    input  logic              kill_en,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [VPPN_W-1:0] lk_vppn,
    output logic [PS_W-1:0]   lk_ps,
    output logic [ASID_W-1:0] lk_asid,
    output logic              lk_g,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_exist,
    output logic [TOTAL-1:0]  exist_vec
);
    localparam int EW = $clog2(TOTAL);

    logic [TOTAL-1:0]  exist_d, exist_q;
    logic [VPPN_W-1:0] vppn_m [TOTAL];
    logic [PS_W-1:0]   ps_m   [TOTAL];
    logic [ASID_W-1:0] asid_m [TOTAL];
    logic              g_m    [TOTAL];
    logic              wr_ok;
    logic              lk_ok;

    assign wr_ok = wr_en && (wr_idx < IDX_W'(TOTAL));
    assign lk_ok = (lk_idx < IDX_W'(TOTAL));

    always_comb begin
        exist_d = exist_q;
        if (kill_en && lk_ok) begin
            exist_d[lk_idx[EW-1:0]] = 1'b0;
        end
        if (wr_ok) begin
            exist_d[wr_idx[EW-1:0]] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exist_q <= '0;
        end else begin
            exist_q <= exist_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            vppn_m[wr_idx[EW-1:0]] <= wr_vppn;
            ps_m[wr_idx[EW-1:0]]   <= wr_ps;
            asid_m[wr_idx[EW-1:0]] <= wr_asid;
            g_m[wr_idx[EW-1:0]]    <= wr_g;
        end
    end

    always_comb begin
        if (lk_ok) begin
            lk_vppn = vppn_m[lk_idx[EW-1:0]];
            lk_ps   = ps_m[lk_idx[EW-1:0]];
            lk_asid = asid_m[lk_idx[EW-1:0]];
            lk_g    = g_m[lk_idx[EW-1:0]];
        end else begin
            lk_vppn = '0;
            lk_ps   = '0;
            lk_asid = '0;
            lk_g    = 1'b0;
        end
        rd_exist = (rd_idx < IDX_W'(TOTAL)) ? exist_q[rd_idx[EW-1:0]] : 1'b0;
    end

    assign exist_vec = exist_q;
endmodule

// File: rtl/tlbinv_engine.sv
module tlbinv_engine
    import tlbinv_pkg::*;
#(
    parameter int WAYS     = 8,
    parameter int LINES    = 256,
    parameter int ASSOC    = 64,
    parameter int VA_W     = 48,
    parameter int VPPN_LSB = 13,
    parameter int PS_W     = 6,
    parameter int ASID_W   = 10,
    parameter int IDX_W    = $clog2(WAYS * LINES + ASSOC) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PS_W-1:0]          stlb_ps,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [VA_W-VPPN_LSB-1:0] wr_vppn,
    input  logic [PS_W-1:0]          wr_ps,
    input  logic [ASID_W-1:0]        wr_asid,
    input  logic                     wr_g,
    input  logic                     cmd_valid,
    input  logic [2:0]               cmd_op,
    input  logic                     cmd_g,
    input  logic [ASID_W-1:0]        cmd_asid,
    input  logic [VA_W-1:0]          cmd_va,
    input  logic [IDX_W-1:0]         cmd_index,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic                     rd_exist,
    output logic                     busy,
    output logic                     flush_pulse
);
    localparam int SA_CNT = WAYS * LINES;
    localparam int TOTAL  = SA_CNT + ASSOC;
    localparam int VPPN_W = VA_W - VPPN_LSB;

    logic              scan_active;
    logic [IDX_W-1:0]  scan_ptr;
    inv_op_e           op_q;
    logic              g_q;
    logic [ASID_W-1:0] asid_q;
    logic [VA_W-1:0]   va_q;
    logic [VPPN_W-1:0] lk_vppn;
    logic [PS_W-1:0]   lk_ps;
    logic [ASID_W-1:0] lk_asid;
    logic              lk_g;
    logic [PS_W-1:0]   ps_eff;
    logic              kill;
    logic              wr_gated;
    logic [TOTAL-1:0]  exist_vec;

    assign wr_gated = wr_en && !busy;
    assign ps_eff   = (scan_ptr < IDX_W'(SA_CNT)) ? stlb_ps : lk_ps;

    tlbinv_scan #(
        .WAYS(WAYS), .LINES(LINES), .ASSOC(ASSOC),
        .IDX_W(IDX_W), .ASID_W(ASID_W), .VA_W(VA_W)
    ) u_scan (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(inv_op_e'(cmd_op)), .cmd_g(cmd_g),
        .cmd_asid(cmd_asid), .cmd_va(cmd_va), .cmd_index(cmd_index),
        .busy(busy), .flush_pulse(flush_pulse), .scan_active(scan_active),
        .scan_ptr(scan_ptr), .op_q(op_q), .g_q(g_q), .asid_q(asid_q), .va_q(va_q)
    );

    tlbinv_store #(
        .TOTAL(TOTAL), .IDX_W(IDX_W), .VPPN_W(VPPN_W),
        .PS_W(PS_W), .ASID_W(ASID_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_gated), .wr_idx(wr_idx), .wr_vppn(wr_vppn), .wr_ps(wr_ps),
        .wr_asid(wr_asid), .wr_g(wr_g),
        .kill_en(scan_active && kill), .lk_idx(scan_ptr),
        .lk_vppn(lk_vppn), .lk_ps(lk_ps), .lk_asid(lk_asid), .lk_g(lk_g),
        .rd_idx(rd_idx), .rd_exist(rd_exist), .exist_vec(exist_vec)
    );

    tlbinv_match #(
        .VA_W(VA_W), .VPPN_LSB(VPPN_LSB), .PS_W(PS_W), .ASID_W(ASID_W)
    ) u_match (
        .op(op_q), .cmd_g(g_q), .cmd_asid(asid_q), .cmd_va(va_q),
        .ent_g(lk_g), .ent_asid(lk_asid), .ent_vppn(lk_vppn), .ps_eff(ps_eff),
        .kill(kill)
    );
endmodule

// File: rtl/tlbinv_checker.sv
module tlbinv_checker #(
    parameter int TOTAL = 2112,
    parameter int IDX_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic             busy,
    input logic             flush_pulse,
    input logic [TOTAL-1:0] exist_vec
);
    localparam int EW = $clog2(TOTAL);

    p_reset_clear_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (exist_vec == '0 && !busy && !flush_pulse));

    p_busy_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_idx < IDX_W'(TOTAL))
        |=> (!exist_vec[$past(wr_idx[EW-1:0])] || $past(exist_vec[wr_idx[EW-1:0]])));

    p_idle_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && wr_idx < IDX_W'(TOTAL)) |=> exist_vec[$past(wr_idx[EW-1:0])]);

    p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid) |=> busy);

    p_start_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |=> (!flush_pulse && !busy));

    p_pulse_ends_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(flush_pulse));
endmodule

bind tlbinv_engine tlbinv_checker #(.TOTAL(TOTAL), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .wr_en(wr_en),
    .wr_idx(wr_idx), .busy(busy), .flush_pulse(flush_pulse), .exist_vec(exist_vec)
);

// File: tb/tlbinv_engine_bench.sv
module tlbinv_engine_bench;
    localparam int WAYS = 8, LINES = 256, ASSOC = 64;
    localparam int SA = WAYS * LINES;
    localparam int TOTAL = SA + ASSOC;
    localparam int IDX_W = $clog2(TOTAL) + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [5:0] stlb_ps = 6'd13;
    logic wr_en = 0, wr_g = 0, cmd_valid = 0, cmd_g = 0;
    logic [IDX_W-1:0] wr_idx = '0, cmd_index = '0, rd_idx = '0;
    logic [34:0] wr_vppn = '0;
    logic [5:0] wr_ps = '0;
    logic [9:0] wr_asid = '0, cmd_asid = '0;
    logic [2:0] cmd_op = '0;
    logic [47:0] cmd_va = '0;
    logic rd_exist, busy, flush_pulse;

    int n_chk = 0, n_bad = 0;
    bit          m_ex [TOTAL];
    logic [34:0] m_vppn [TOTAL];
    logic [5:0]  m_ps [TOTAL];
    logic [9:0]  m_asid [TOTAL];
    bit          m_g [TOTAL];
    logic [47:0] va_pool [4];

    always #10 clk = ~clk;

    tlbinv_engine u_tlbinv_engine (
        .clk(clk), .rst_n(rst_n), .stlb_ps(stlb_ps),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vppn(wr_vppn), .wr_ps(wr_ps),
        .wr_asid(wr_asid), .wr_g(wr_g),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_g(cmd_g), .cmd_asid(cmd_asid),
        .cmd_va(cmd_va), .cmd_index(cmd_index),
        .rd_idx(rd_idx), .rd_exist(rd_exist), .busy(busy), .flush_pulse(flush_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R7 page rule, computed with the shift form
    function automatic bit page_hit(input int i, input logic [47:0] va);
        int ps;
        logic [63:0] lhs, rhs;
        ps  = (i < SA) ? int'(stlb_ps) : int'(m_ps[i]);
        lhs = 64'(va) >> (ps + 1);
        rhs = 64'(m_vppn[i]) >> (ps + 1 - 13);
        return lhs == rhs;
    endfunction

    // R9 scope
    function automatic bit in_scope(input int op, input int idx, input int i);
        if (op == 7) return 0;
        if (op == 5 || op == 6) begin
            if (idx < SA) return (i < SA) && ((i % LINES) == (idx % LINES));
            if (idx < TOTAL) return i >= SA;
            return 0;
        end
        return 1;
    endfunction

    function automatic bit kills(input int op, input int i, input bit g,
                                 input logic [9:0] asid, input logic [47:0] va);
        bit am;
        am = (m_asid[i] == asid);
        case (op)
            0: return 1;
            1: return m_g[i] == g;
            2: return !m_g[i] && am;
            3: return !m_g[i] && am && page_hit(i, va);
            4: return (m_g[i] || am) && page_hit(i, va);
            5: return !m_g[i] && am;
            6: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int scan_len(input int op, input int idx);
        if (op == 7) return 0;
        if (op == 5 || op == 6) begin
            if (idx < SA) return WAYS;
            if (idx < TOTAL) return ASSOC;
            return 0;
        end
        return TOTAL;
    endfunction

    task automatic write_ent(input int idx, input logic [34:0] vppn, input logic [5:0] ps,
                             input logic [9:0] asid, input bit g);
        @(negedge clk);
        wr_en = 1; wr_idx = IDX_W'(idx); wr_vppn = vppn; wr_ps = ps; wr_asid = asid; wr_g = g;
        @(negedge clk);
        wr_en = 0;
        m_ex[idx] = 1; m_vppn[idx] = vppn; m_ps[idx] = ps; m_asid[idx] = asid; m_g[idx] = g;
    endtask

    task automatic fill();
        for (int i = 0; i < TOTAL; i++) begin
            if ($urandom_range(3) != 0) begin
                logic [34:0] v;
                logic [5:0] p;
                v = va_pool[$urandom_range(3)][47:13] ^ 35'($urandom_range(1) << $urandom_range(9));
                case ($urandom_range(2))
                    0: p = 6'd13;
                    1: p = 6'd15;
                    default: p = 6'd20;
                endcase
                write_ent(i, v, p, 10'($urandom_range(3) + 1), ($urandom_range(3) == 0));
            end
        end
    endtask

    task automatic check_all(input string req);
        int bad = 0, first = -1;
        for (int i = 0; i < TOTAL; i++) begin
            rd_idx = IDX_W'(i);
            #1;
            if (rd_exist !== m_ex[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        chk(bad == 0, req, bad, 0);
        if (bad != 0) $display("  first mismatching entry %0d", first);
    endtask

    task automatic do_cmd(input int op, input bit g, input logic [9:0] asid,
                          input logic [47:0] va, input int idx, input bit inject,
                          input string req);
        int len, cnt, pulses, pulse_at, inj_idx;
        len = scan_len(op, idx);
        for (int i = 0; i < TOTAL; i++)
            if (m_ex[i] && in_scope(op, idx, i) && kills(op, i, g, asid, va)) m_ex[i] = 0;
        inj_idx = -1;
        if (inject)
            for (int i = SA; i < TOTAL; i++)
                if (!m_ex[i] && inj_idx < 0) inj_idx = i;
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'(op); cmd_g = g; cmd_asid = asid; cmd_va = va;
        cmd_index = IDX_W'(idx);
        @(negedge clk);
        cmd_valid = 0;
        cnt = 0; pulses = 0; pulse_at = -1;
        while (busy) begin
            cnt++;
            if (flush_pulse) begin pulses++; pulse_at = cnt; end
            if (inject && cnt == 2) begin
                cmd_valid = 1; cmd_op = 3'd0;
                if (inj_idx >= 0) begin
                    wr_en = 1; wr_idx = IDX_W'(inj_idx); wr_vppn = '0;
                    wr_ps = 6'd13; wr_asid = 10'd1; wr_g = 0;
                end
            end else begin
                cmd_valid = 0; wr_en = 0;
            end
            @(negedge clk);
        end
        cmd_valid = 0; wr_en = 0;
        chk(cnt == len + 1, {req, " R3 busy length"}, cnt, len + 1);
        chk(pulses == 1 && pulse_at == len + 1, {req, " R4 flush pulse"}, pulse_at, len + 1);
        check_all(req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd11));
        for (int k = 0; k < 4; k++) va_pool[k] = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(busy == 0 && flush_pulse == 0, "R1 idle after reset", busy, 0);
        check_all("R1 exist bits cleared");

        fill(); check_all("R2 entries written");
        do_cmd(0, 0, 0, 0, 0, 0, "R5 invalidate all");
        fill(); do_cmd(1, 1, 0, 0, 0, 0, "R5 by global=1");
        do_cmd(1, 0, 0, 0, 0, 0, "R5 by global=0");
        fill(); do_cmd(2, 0, 10'd2, 0, 0, 0, "R6 asid");
        fill(); stlb_ps = 6'd13;
        do_cmd(3, 0, 10'd1, va_pool[0], 0, 0, "R8 R7 page+asid ps13");
        do_cmd(4, 0, 10'd3, va_pool[1], 0, 0, "R8 R7 page or global");
        stlb_ps = 6'd20;
        do_cmd(3, 0, 10'd2, va_pool[2], 0, 0, "R7 shared size 20");
        do_cmd(4, 0, 10'd4, va_pool[3], 0, 0, "R7 R8 global-only page");
        stlb_ps = 6'd13;
        fill(); do_cmd(5, 0, 10'd1, 0, 773, 0, "R9 R10 clear one line");
        do_cmd(6, 0, 0, 0, 10, 0, "R9 R10 flush one line");
        do_cmd(5, 0, 10'd2, 0, 2100, 0, "R9 R10 clear assoc part");
        do_cmd(6, 0, 0, 0, SA, 0, "R9 flush assoc part boundary");
        fill(); do_cmd(6, 0, 0, 0, 3000, 0, "R9 out of range index");
        do_cmd(6, 0, 0, 0, TOTAL, 0, "R9 index equal total");
        do_cmd(7, 0, 0, 0, 0, 0, "R3 op none");
        do_cmd(6, 0, 0, 0, 300, 1, "R2 busy ignores cmd and write");
        for (int r = 0; r < 10; r++) begin
            int op, idx;
            fill();
            op = $urandom_range(7);
            case ($urandom_range(2))
                0: idx = $urandom_range(SA - 1);
                1: idx = SA + $urandom_range(ASSOC - 1);
                default: idx = TOTAL + $urandom_range(100);
            endcase
            stlb_ps = ($urandom_range(1) != 0) ? 6'd13 : 6'd15;
            do_cmd(op, 1'($urandom_range(1)), 10'($urandom_range(3) + 1),
                   va_pool[$urandom_range(3)], idx, 0, "R5 R6 R8 R10 random");
        end
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule